// File: doc/BRIEF.md
# Root Port Error Message Queue

This block holds error messages that a PCIe root port has received, in arrival order, until software reads them. Each message comes in as a one-cycle push strobe with a 2-bit severity code and the 16-bit requester ID of the device that sent it. The block does not decode transaction layer packets. An upstream receiver hands it the severity and the requester ID directly.

Software sees the oldest stored message through one 32-bit register at offset 0x154. The read word packs a valid flag with the severity and the requester ID of the head entry. A write of any data to that offset discards the head entry. Each accepted message severity also produces a one-cycle event pulse for the interrupt decode unit. The queue depth is a parameter. A message that arrives while the queue is full is lost, and a sticky flag records the loss.

Top module: `err_msg_fifo`

## Requirements
- R1: A read at offset 0x154 returns a word with these fields: bit 18 is 1 when an entry is held, bits 17:16 are the head severity, bits 15:0 are the head requester ID, bit 19 is the overflow flag, and every other bit is 0. When the queue is empty, bits 18:0 read as 0.
- R2: Entries leave the queue in the order they were pushed, and each keeps its severity and requester ID.
- R3: A write to offset 0x154 removes the head entry. A write to any other offset changes nothing.
- R4: A write to offset 0x154 while the queue is empty has no effect.
- R5: The queue holds DEPTH entries (16 by default). Pushing a valid message into a full queue without a pop in the same cycle drops the message and sets bit 19. Bit 19 then stays 1 until reset.
- R6: When a push and an effective pop happen in the same cycle, both take effect and the entry count does not change. This holds when the queue is full, and then no overflow occurs. When the queue is empty, the pop has no effect and the push is stored.
- R7: A push with severity 0 (correctable), 1 (non-fatal) or 2 (fatal) sets event output bit 9, 10 or 11 respectively for exactly the one cycle after the push edge. This happens even when the message is dropped. All other event bits stay 0.
- R8: A push with severity code 3 is ignored: nothing is stored, no event is raised, and the overflow flag does not change.
- R9: While reset is asserted, and right after it, the queue is empty, the overflow flag is 0 and the event output is 0.
- R10: A read at any offset other than 0x154 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_push | input | 1 | One-cycle strobe: a message has arrived |
| msg_sev | input | 2 | Severity of the message: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msg_rid | input | 16 | Requester ID of the message |
| csr_addr | input | ADDR_W (12) | Register offset used for both reads and writes |
| csr_wr | input | 1 | Write strobe; a write at offset 0x154 pops the head entry |
| csr_rdata | output | 32 | Read data for csr_addr |
| evt_o | output | 32 | Event pulses toward interrupt decode, bits 11:9 |

## Verification
The bench keeps a model of the queue and compares the read word and the event output on every cycle.

- Single pushes of each severity, followed by idle cycles, show that the event bit matches the severity and lasts one cycle, and that code 3 is discarded.
- Filling the queue from empty to full and then pushing past full shows the exact depth, the drop, the overflow flag and its stickiness. Draining the queue afterwards shows the order and the stored contents.
- Back-to-back push-with-pop cycles on a full queue, and again on an empty one, separate the simultaneous-operation rule from the full and empty boundaries.
- Writes and reads at a neighbouring offset show that address decode is exact.

// File: rtl/err_msg_fifo_pkg.sv
// Shared types and field positions for the root port error message queue.
package err_msg_fifo_pkg;

    typedef enum logic [1:0] {
        SEV_CORR     = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_RSVD     = 2'd3
    } sev_e;

    typedef struct packed {
        sev_e        sev;
        logic [15:0] rid;
    } entry_t;

    localparam int ENTRY_W   = $bits(entry_t);
    localparam int VALID_POS = 18;
    localparam int OVF_POS   = 19;
    localparam int EVT_BASE  = 9;
    localparam int NUM_SEV   = 3;

endpackage

// File: rtl/errq_store.sv
// Circular storage for error entries.
// Assumes: push_i and pop_i are single-cycle requests. A pop on an empty
// queue is ignored. A push on a full queue is accepted only when a pop
// takes effect in the same cycle; otherwise it is dropped and drop_o is high.
module errq_store
    import err_msg_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_i,
    input  logic   pop_i,
    input  entry_t din_i,
    output entry_t head_o,
    output logic   empty_o,
    output logic   full_o,
    output logic   drop_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   cnt;
    logic            pop_eff;
    logic            push_eff;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests take effect this cycle.
    always_comb begin
        empty_o  = (cnt == '0);
        full_o   = (cnt == FULL_CNT);
        pop_eff  = pop_i && !empty_o;
        push_eff = push_i && (!full_o || pop_eff);
        drop_o   = push_i && full_o && !pop_eff;
    end

    // Write an accepted entry into the slot at the tail.
    always_ff @(posedge clk) begin
        if (push_eff) begin
            mem[wr_ptr] <= din_i;
        end
    end

    // Advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_eff) wr_ptr <= bump(wr_ptr);
            if (pop_eff)  rd_ptr <= bump(rd_ptr);
            case ({push_eff, pop_eff})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Present the oldest entry.
    always_comb head_o = mem[rd_ptr];

endmodule

// File: rtl/errq_event.sv
// Turns each accepted message severity into a one-cycle event pulse.
// Assumes: msg_ok is already qualified, so reserved severities never reach it.
// The pulse appears in the cycle after the push edge.
module errq_event
    import err_msg_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_ok,
    input  sev_e        sev,
    output logic [31:0] evt_o
);

    logic [NUM_SEV-1:0] hit_d;
    logic [NUM_SEV-1:0] hit_q;

    for (genvar g = 0; g < NUM_SEV; g++) begin : g_sev
        assign hit_d[g] = msg_ok && (sev == sev_e'(g));
    end

    // Register the decoded severity so each pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit_d;
    end

    // Place the pulses at their event bit positions.
    always_comb begin
        evt_o = '0;
        evt_o[EVT_BASE +: NUM_SEV] = hit_q;
    end

endmodule

// File: rtl/errq_regview.sv
// Register decode: builds the read word for the queue head and turns a
// write at the queue offset into a pop request.
// Assumes: the caller ignores pop_req when the queue is empty.
module errq_regview
    import err_msg_fifo_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(12'h154)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  entry_t            head,
    input  logic              empty,
    input  logic              ovf,
    output logic [31:0]       rdata,
    output logic              pop_req
);

    logic        hit;
    logic [31:0] word;

    // Decode the address, then assemble the status word.
    always_comb begin
        hit     = (addr == REG_OFFSET);
        pop_req = wr && hit;
        word    = '0;
        if (!empty) begin
            word[ENTRY_W-1:0] = head;
            word[VALID_POS]   = 1'b1;
        end
        word[OVF_POS] = ovf;
        rdata = hit ? word : '0;
    end

endmodule

// File: rtl/err_msg_fifo.sv
// Top of the root port error message queue: storage, register view,
// sticky overflow flag and event pulses.
// Assumes: one message per cycle at most; severity code 3 is discarded.
module err_msg_fifo
    import err_msg_fifo_pkg::*;
#(
    parameter int              DEPTH      = 16,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(12'h154)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_push,
    input  logic [1:0]        msg_sev,
    input  logic [15:0]       msg_rid,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_wr,
    output logic [31:0]       csr_rdata,
    output logic [31:0]       evt_o
);

    sev_e   sev_in;
    logic   msg_ok;
    entry_t din;
    entry_t head;
    logic   fifo_empty;
    logic   fifo_full;
    logic   drop;
    logic   pop_req;
    logic   ovf_q;

    // Qualify incoming messages and pack them as entries.
    always_comb begin
        sev_in = sev_e'(msg_sev);
        msg_ok = msg_push && (sev_in != SEV_RSVD);
        din    = '{sev: sev_in, rid: msg_rid};
    end

    errq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (msg_ok),
        .pop_i   (pop_req),
        .din_i   (din),
        .head_o  (head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full),
        .drop_o  (drop)
    );

    errq_regview #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_view (
        .addr    (csr_addr),
        .wr      (csr_wr),
        .head    (head),
        .empty   (fifo_empty),
        .ovf     (ovf_q),
        .rdata   (csr_rdata),
        .pop_req (pop_req)
    );

    errq_event u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .msg_ok (msg_ok),
        .sev    (sev_in),
        .evt_o  (evt_o)
    );

    // Hold the overflow flag from the first dropped message until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (drop) ovf_q <= 1'b1;
    end

endmodule

// File: rtl/err_msg_fifo_chk.sv
// Property checker for err_msg_fifo, attached with bind below.
module err_msg_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_push,
    input logic [1:0]  msg_sev,
    input logic        csr_wr,
    input logic [31:0] csr_rdata,
    input logic [31:0] evt_o,
    input logic        fifo_empty,
    input logic        fifo_full,
    input logic        pop_req,
    input logic        ovf_q
);

    // R1: an empty queue reads zero in the valid, severity and ID fields
    assert_empty_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (csr_rdata[18:0] == 19'd0));

    // R7: a valid push gives exactly one severity event on the next cycle
    assert_evt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && msg_sev != 2'd3) |=> ($countones(evt_o[11:9]) == 1));

    // R7: never more than one event bit at a time
    assert_evt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o));

    // R8: a reserved-code push raises no event
    assert_rsvd_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && msg_sev == 2'd3) |=> (evt_o == 32'd0));

    // R5: the overflow flag is sticky
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R5: a push into a full queue without a pop sets overflow
    assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && msg_sev != 2'd3 && fifo_full && !pop_req) |=> ovf_q);

    // R6: push together with pop on a full queue is no overflow
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_push && msg_sev != 2'd3 && fifo_full && pop_req && !ovf_q)
        |=> (!ovf_q && fifo_full));

    // R4: a pop on an empty queue leaves it empty
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && csr_wr && !msg_push) |=> fifo_empty);

endmodule

bind err_msg_fifo err_msg_fifo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_push   (msg_push),
    .msg_sev    (msg_sev),
    .csr_wr     (csr_wr),
    .csr_rdata  (csr_rdata),
    .evt_o      (evt_o),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .pop_req    (pop_req),
    .ovf_q      (ovf_q)
);

// File: tb/sim_err_msg_fifo.sv
// Bench for err_msg_fifo: a queue model checks the read word and events each cycle.
module sim_err_msg_fifo;

    localparam int          D   = 16;
    localparam logic [11:0] OFF = 12'h154;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_push = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_rid = 16'd0;
    logic [11:0] csr_addr = OFF;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_rdata;
    logic [31:0] evt_o;

    int vectors = 0;
    int errors  = 0;
    logic [17:0] mq[$];
    logic        m_ovf = 1'b0;

    always #2 clk = ~clk;

    err_msg_fifo u0 (
        .clk(clk), .rst_n(rst_n), .msg_push(msg_push), .msg_sev(msg_sev),
        .msg_rid(msg_rid), .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_rdata(csr_rdata), .evt_o(evt_o)
    );

    function automatic logic [15:0] rid_of(input int i);
        return 16'((i * 40503 + 7) & 16'hFFFF);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; msg_push = 1'b0; csr_wr = 1'b0; csr_addr = OFF;
        repeat (2) @(posedge clk);
        #1;
        mq.delete();
        m_ovf = 1'b0;
        check("R9 rdata", csr_rdata, 32'd0);
        check("R9 evt", evt_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock cycle: drive, update the model, compare after the edge.
    task automatic cyc(input logic p, input logic [1:0] s, input logic [15:0] r,
                       input logic w, input logic [11:0] a, input string tag);
        logic        pop_eff, ok;
        logic [31:0] exp_evt, exp_rd;
        @(negedge clk);
        msg_push = p; msg_sev = s; msg_rid = r; csr_wr = w; csr_addr = a;
        pop_eff = w && (a == OFF) && (mq.size() > 0);
        ok      = p && (s != 2'd3);
        exp_evt = ok ? (32'd1 << (9 + s)) : 32'd0;
        if (pop_eff) void'(mq.pop_front());
        if (ok) begin
            if (mq.size() < D) mq.push_back({s, r});
            else m_ovf = 1'b1;
        end
        @(posedge clk);
        #1;
        exp_rd = 32'd0;
        if (a == OFF) begin
            exp_rd[19] = m_ovf;
            if (mq.size() > 0) begin
                exp_rd[18]   = 1'b1;
                exp_rd[17:0] = mq[0];
            end
        end
        check({tag, " rdata"}, csr_rdata, exp_rd);
        check(ok ? "R7 evt" : "R8 evt", evt_o, exp_evt);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R4: pops on an empty queue
        cyc(0, 0, 0, 1, OFF, "R4");
        cyc(0, 0, 0, 1, OFF, "R4");
        // R7: each severity, then idle to see the pulse end
        for (int s = 0; s < 3; s++) begin
            cyc(1, 2'(s), rid_of(s), 0, OFF, "R1");
            cyc(0, 0, 0, 0, OFF, "R7");
        end
        // R8: reserved code is not stored
        cyc(1, 2'd3, 16'hBEEF, 0, OFF, "R8");
        // R2: drain in order, then one pop past empty (R4)
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, OFF, "R2");
        cyc(0, 0, 0, 1, OFF, "R4");
        // R5: fill to the depth, then overflow
        for (int i = 0; i < D; i++) cyc(1, 2'(i % 3), rid_of(i + 10), 0, OFF, "R2");
        cyc(1, 2'd2, 16'h1234, 0, OFF, "R5");
        cyc(1, 2'd0, 16'h4321, 0, OFF, "R5");
        // R3/R10: write and read at a neighbouring offset
        cyc(0, 0, 0, 1, 12'h150, "R10");
        cyc(0, 0, 0, 1, 12'h158, "R3");
        cyc(0, 0, 0, 0, OFF, "R3");
        for (int i = 0; i < D; i++) cyc(0, 0, 0, 1, OFF, "R2");
        cyc(0, 0, 0, 1, OFF, "R5");
        // R6: push with pop on a full queue, then drain
        do_reset();
        for (int i = 0; i < D; i++) cyc(1, 2'((i + 1) % 3), rid_of(i + 50), 0, OFF, "R6");
        for (int i = 0; i < 20; i++) cyc(1, 2'(i % 3), rid_of(i + 90), 1, OFF, "R6");
        for (int i = 0; i < D; i++) cyc(0, 0, 0, 1, OFF, "R6");
        // R6: push with pop on an empty queue
        cyc(1, 2'd1, 16'hA5A5, 1, OFF, "R6");
        cyc(0, 0, 0, 0, 12'h000, "R10");
        cyc(0, 0, 0, 1, OFF, "R6");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule